// File: doc/BRIEF.md
# Vector Coprocessor Control and Status Registers

This block is the host-visible register set for a small vector coprocessor. A host bus reads and writes it with single-cycle strobes. It holds two DMA address registers and two DMA length registers, one length register per transfer direction. Writing a length register launches a transfer request towards the DMA engine. The block also holds a status word that is changed only through paired set/clear command bits, a hardware semaphore, and the coprocessor program counter.

The status word carries these flags: halt, broke, single-step, interrupt-on-break and eight general signal flags. When halt is clear, a ratio gate grants the execution pipeline two steps for every three host cycles. Status commands can also ask the host interrupt controller to raise or lower the coprocessor interrupt. The DMA engine, the memories and the pipeline lie outside the block. They appear only as a start strobe with its fields, a step-grant output, a break input and a program-counter value.

Top module: `cop_csr`

## Requirements
- R1: After reset the status word reads 0x1 (halt set, all other flags clear), the PC reads 0, the semaphore is free and no steps are granted.
- R2: The memory-side DMA address (offset 0x00) keeps only bits under mask 0x1FF8, and the external-side DMA address (offset 0x04) keeps only bits under mask 0xFFFFF8, both on write and on read-back.
- R3: A write to offset 0x08 or 0x0C stores the length. On the next cycle it pulses `dma_start` for one cycle, with `dma_dir` 0 for 0x08 and 1 for 0x0C, `dma_len` set to the written value and `dma_bank` set to bit 12 of the stored memory-side address.
- R4: A status write (offset 0x10) with command bit 0 set and bit 1 clear clears halt. Bit 1 set with bit 0 clear sets halt. Both set, or neither, leaves halt unchanged. `run_en` is the inverse of halt.
- R5: In a status write, command bit 4 set alone gives a one-cycle `irq_raise`, and bit 3 set alone gives a one-cycle `irq_lower`. Both set, or neither, give no pulse.
- R6: A `core_brk` pulse sets the broke flag (status bit 1). Status command bit 2 clears it. If both happen in the same cycle, the break wins.
- R7: Single-step (status bit 2, command clear 5 / set 6), interrupt-on-break (status bit 3, command clear 7 / set 8) and signal k (status bit 4+k, command clear 9+2k / set 10+2k) each follow the clear-only, set-only, both-or-neither-unchanged rule.
- R8: A read of offset 0x1C returns the semaphore in bit 0 and then takes it, so later reads return 1. Any write to 0x1C frees it. A read and a release in the same cycle leave it free.
- R9: In the PC window, offset 0 is writable only while halt is set. The PC reads back masked with 0xFFC. An accepted write pulses `pc_load` for one cycle.
- R10: While halt is clear, every third cycle `step_cnt` shows 2 for one cycle and 0 otherwise. The first grant comes on the third cycle after halt clears. A set-halt command restarts the phase.
- R11: Offset 0x14 returns `dma_full` in bit 0, and offset 0x18 returns 0. Misaligned offsets, offsets of 0x20 and above, and non-zero PC-window offsets return 0 with a one-cycle `bus_rerr`.
- R12: Read data appears with `bus_rvalid` on the cycle after `bus_rd`. It shows the state from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_pc_win | input | 1 | Selects the PC window instead of the control window |
| bus_addr | input | 8 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| bus_rerr | output | 1 | Unmapped read, one-cycle pulse |
| core_brk | input | 1 | Break event from the pipeline |
| dma_full | input | 1 | DMA queue full indication from the engine |
| dma_start | output | 1 | DMA request pulse |
| dma_dir | output | 1 | Transfer direction of the request |
| dma_bank | output | 1 | Memory bank of the request |
| dma_len | output | 32 | Length word of the request |
| dma_mem_addr | output | 32 | Stored memory-side address |
| dma_ext_addr | output | 32 | Stored external-side address |
| irq_raise | output | 1 | Interrupt raise request pulse |
| irq_lower | output | 1 | Interrupt lower request pulse |
| run_en | output | 1 | Coprocessor running (halt clear) |
| step_cnt | output | 2 | Steps granted this cycle |
| pc_value | output | 12 | Current program counter |
| pc_load | output | 1 | PC was written by the host |

## Verification
Suppose a status flag has taken the wrong value. It shows in the status word on the next read. For halt, it shows at once on `run_en`, in the same cycle, and the step grants move out of their three-cycle cadence within three cycles. A lost or stuck semaphore shows on the second read of 0x1C. A stale bank bit or direction shows on the `dma_start` pulse one cycle after the length write. The bench model compares every registered output on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/cop_csr_pkg.sv
package cop_csr_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;

    localparam logic [DATA_W-1:0] MEM_ADDR_MASK = 32'h0000_1FF8;
    localparam logic [DATA_W-1:0] EXT_ADDR_MASK = 32'h00FF_FFF8;
    localparam logic [DATA_W-1:0] PC_MASK       = 32'h0000_0FFC;
    localparam int BANK_BIT = 12;

    // status word bit positions
    localparam int ST_HALT   = 0;
    localparam int ST_BROKE  = 1;
    localparam int ST_SSTEP  = 2;
    localparam int ST_IOB    = 3;
    localparam int ST_SIG    = 4;

    // command bit positions in a status write
    localparam int CMD_CLR_HALT  = 0;
    localparam int CMD_SET_HALT  = 1;
    localparam int CMD_CLR_BROKE = 2;
    localparam int CMD_CLR_IRQ   = 3;
    localparam int CMD_SET_IRQ   = 4;
    localparam int CMD_CLR_SSTEP = 5;
    localparam int CMD_SET_SSTEP = 6;
    localparam int CMD_CLR_IOB   = 7;
    localparam int CMD_SET_IOB   = 8;
    localparam int CMD_SIG       = 9;

    typedef enum logic [2:0] {
        REG_MEM_ADDR = 3'd0,
        REG_EXT_ADDR = 3'd1,
        REG_LEN_IN   = 3'd2,
        REG_LEN_OUT  = 3'd3,
        REG_STATUS   = 3'd4,
        REG_DMA_FULL = 3'd5,
        REG_DMA_BUSY = 3'd6,
        REG_SEM      = 3'd7
    } csr_sel_e;

    typedef struct packed {
        logic     hit;
        csr_sel_e sel;
    } csr_dec_t;

    typedef enum logic [1:0] {
        PAIR_KEEP = 2'd0,
        PAIR_SET  = 2'd1,
        PAIR_CLR  = 2'd2
    } pair_act_e;

    typedef struct packed {
        logic              start;
        logic              dir;
        logic              bank;
        logic [DATA_W-1:0] len;
    } dma_req_t;

    function automatic csr_dec_t decode_csr(input logic [OFF_W-1:0] off);
        csr_dec_t d;
        d.hit = (off[1:0] == 2'b00) && (off[OFF_W-1:5] == '0);
        d.sel = csr_sel_e'(off[4:2]);
        return d;
    endfunction

    function automatic pair_act_e decode_pair(input logic clr, input logic set);
        if (clr && !set) return PAIR_CLR;
        if (set && !clr) return PAIR_SET;
        return PAIR_KEEP;
    endfunction

    function automatic logic apply_pair(input logic cur, input pair_act_e act);
        case (act)
            PAIR_SET: return 1'b1;
            PAIR_CLR: return 1'b0;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/cop_status_reg.sv
module cop_status_reg
    import cop_csr_pkg::*;
#(
    parameter int NUM_SIG = 8,
    localparam int STAT_W = ST_SIG + NUM_SIG,
    localparam int CMD_W  = CMD_SIG + 2 * NUM_SIG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              brk_evt,
    output logic [STAT_W-1:0] status_word,
    output logic              halt,
    output logic              halt_set_req,
    output logic              irq_raise,
    output logic              irq_lower
);

    logic              halt_q;
    logic              broke_q;
    logic              sstep_q;
    logic              iob_q;
    logic [NUM_SIG-1:0] sig_q;
    pair_act_e         halt_act;
    pair_act_e         irq_act;

    assign halt_act     = decode_pair(cmd[CMD_CLR_HALT], cmd[CMD_SET_HALT]);
    assign irq_act      = decode_pair(cmd[CMD_CLR_IRQ], cmd[CMD_SET_IRQ]);
    assign halt_set_req = cmd_en && (halt_act == PAIR_SET);

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q    <= 1'b1;
            broke_q   <= 1'b0;
            sstep_q   <= 1'b0;
            iob_q     <= 1'b0;
            irq_raise <= 1'b0;
            irq_lower <= 1'b0;
        end else begin
            irq_raise <= cmd_en && (irq_act == PAIR_SET);
            irq_lower <= cmd_en && (irq_act == PAIR_CLR);
            if (cmd_en) begin
                halt_q  <= apply_pair(halt_q, halt_act);
                sstep_q <= apply_pair(sstep_q,
                           decode_pair(cmd[CMD_CLR_SSTEP], cmd[CMD_SET_SSTEP]));
                iob_q   <= apply_pair(iob_q,
                           decode_pair(cmd[CMD_CLR_IOB], cmd[CMD_SET_IOB]));
            end
            if (brk_evt) begin
                broke_q <= 1'b1;
            end else if (cmd_en && cmd[CMD_CLR_BROKE]) begin
                broke_q <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < NUM_SIG; k++) begin : g_sig
        always_ff @(posedge clk) begin
            if (rst) begin
                sig_q[k] <= 1'b0;
            end else if (cmd_en) begin
                sig_q[k] <= apply_pair(sig_q[k],
                            decode_pair(cmd[CMD_SIG + 2*k], cmd[CMD_SIG + 2*k + 1]));
            end
        end
    end

    assign halt = halt_q;
    assign status_word = {sig_q, iob_q, sstep_q, broke_q, halt_q};

    // R4: halt moves only on a status write
    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cmd_en |=> $stable(halt_q));

    // R5: never raise and lower together
    assert_irq_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(irq_raise && irq_lower));

    // R6: a break event always leaves broke set
    assert_broke_set_R6: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> broke_q);

endmodule

// File: rtl/cop_step_gate.sv
module cop_step_gate #(
    parameter int NUM = 2,
    parameter int DEN = 3,
    localparam int CW = $clog2(DEN + 1),
    localparam int SW = $clog2(NUM + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          zero_req,
    output logic [SW-1:0] step_cnt
);

    localparam logic [CW:0]   DEN_V = (CW + 1)'(DEN);
    localparam logic [SW-1:0] NUM_V = SW'(NUM);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   nxt;

    assign nxt = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            step_cnt <= '0;
        end else if (zero_req) begin
            cnt_q    <= '0;
            step_cnt <= '0;
        end else if (run_en) begin
            if (nxt >= DEN_V) begin
                cnt_q    <= CW'(nxt - DEN_V);
                step_cnt <= NUM_V;
            end else begin
                cnt_q    <= nxt[CW-1:0];
                step_cnt <= '0;
            end
        end else begin
            step_cnt <= '0;
        end
    end

    // R10: grants only follow a running cycle
    assert_grant_run_R10: assert property (@(posedge clk) disable iff (rst)
        (step_cnt != '0) |-> $past(run_en));

    // R10: grants are never back to back
    assert_grant_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        (step_cnt != '0) |=> (step_cnt == '0));

endmodule

// File: rtl/cop_sem.sv
module cop_sem (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic release_req,
    output logic sem_busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sem_busy <= 1'b0;
        end else if (release_req) begin
            sem_busy <= 1'b0;
        end else if (take) begin
            sem_busy <= 1'b1;
        end
    end

    // R8: a release always frees the semaphore
    assert_sem_release_R8: assert property (@(posedge clk) disable iff (rst)
        release_req |=> !sem_busy);

    // R8: a lone read takes it
    assert_sem_take_R8: assert property (@(posedge clk) disable iff (rst)
        (take && !release_req) |=> sem_busy);

endmodule

// File: rtl/cop_csr.sv
module cop_csr
    import cop_csr_pkg::*;
#(
    parameter int PC_W     = 12,
    parameter int NUM_SIG  = 8,
    parameter int STEP_NUM = 2,
    parameter int STEP_DEN = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic                            bus_pc_win,
    input  logic [OFF_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic                            bus_rvalid,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic                            bus_rerr,
    input  logic                            core_brk,
    input  logic                            dma_full,
    output logic                            dma_start,
    output logic                            dma_dir,
    output logic                            dma_bank,
    output logic [DATA_W-1:0]               dma_len,
    output logic [DATA_W-1:0]               dma_mem_addr,
    output logic [DATA_W-1:0]               dma_ext_addr,
    output logic                            irq_raise,
    output logic                            irq_lower,
    output logic                            run_en,
    output logic [$clog2(STEP_NUM+1)-1:0]   step_cnt,
    output logic [PC_W-1:0]                 pc_value,
    output logic                            pc_load
);

    localparam int STAT_W = ST_SIG + NUM_SIG;
    localparam int CMD_W  = CMD_SIG + 2 * NUM_SIG;
    localparam logic [PC_W-1:0] PC_KEEP = PC_MASK[PC_W-1:0];

    csr_dec_t          dec;
    logic              csr_wr;
    logic              csr_rd;
    logic              pc_hit;
    logic              halt;
    logic              halt_set_req;
    logic [STAT_W-1:0] status_word;
    logic              sem_busy;
    logic              sem_take;
    logic              sem_rel;
    logic              status_wr;
    logic [DATA_W-1:0] mem_addr_q;
    logic [DATA_W-1:0] ext_addr_q;
    logic [DATA_W-1:0] len_q [2];
    logic [PC_W-1:0]   pc_q;
    dma_req_t          req_q;
    logic [DATA_W-1:0] rd_val;
    logic              rd_hit;

    assign dec       = decode_csr(bus_addr);
    assign csr_wr    = bus_wr && !bus_pc_win && dec.hit;
    assign csr_rd    = bus_rd && !bus_pc_win && dec.hit;
    assign pc_hit    = bus_pc_win && (bus_addr == '0);
    assign status_wr = csr_wr && (dec.sel == REG_STATUS);
    assign sem_take  = csr_rd && (dec.sel == REG_SEM);
    assign sem_rel   = csr_wr && (dec.sel == REG_SEM);

    cop_status_reg #(.NUM_SIG(NUM_SIG)) u_status (
        .clk          (clk),
        .rst          (rst),
        .cmd_en       (status_wr),
        .cmd          (bus_wdata[CMD_W-1:0]),
        .brk_evt      (core_brk),
        .status_word  (status_word),
        .halt         (halt),
        .halt_set_req (halt_set_req),
        .irq_raise    (irq_raise),
        .irq_lower    (irq_lower)
    );

    cop_step_gate #(.NUM(STEP_NUM), .DEN(STEP_DEN)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .run_en   (!halt),
        .zero_req (halt_set_req),
        .step_cnt (step_cnt)
    );

    cop_sem u_sem (
        .clk         (clk),
        .rst         (rst),
        .take        (sem_take),
        .release_req (sem_rel),
        .sem_busy    (sem_busy)
    );

    // address and length registers, DMA request
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr_q <= '0;
            ext_addr_q <= '0;
            len_q[0]   <= '0;
            len_q[1]   <= '0;
            req_q      <= '0;
        end else begin
            req_q.start <= 1'b0;
            if (csr_wr) begin
                case (dec.sel)
                    REG_MEM_ADDR: mem_addr_q <= bus_wdata & MEM_ADDR_MASK;
                    REG_EXT_ADDR: ext_addr_q <= bus_wdata & EXT_ADDR_MASK;
                    REG_LEN_IN, REG_LEN_OUT: begin
                        len_q[dec.sel == REG_LEN_OUT] <= bus_wdata;
                        req_q.start <= 1'b1;
                        req_q.dir   <= (dec.sel == REG_LEN_OUT);
                        req_q.bank  <= mem_addr_q[BANK_BIT];
                        req_q.len   <= bus_wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // program counter, writable only while halted
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            pc_load <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            if (bus_wr && pc_hit && halt) begin
                pc_q    <= bus_wdata[PC_W-1:0] & PC_KEEP;
                pc_load <= 1'b1;
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        rd_hit = 1'b0;
        if (bus_pc_win) begin
            rd_hit = pc_hit;
            rd_val = DATA_W'(pc_q);
        end else begin
            rd_hit = dec.hit;
            case (dec.sel)
                REG_MEM_ADDR: rd_val = mem_addr_q;
                REG_EXT_ADDR: rd_val = ext_addr_q;
                REG_LEN_IN:   rd_val = len_q[0];
                REG_LEN_OUT:  rd_val = len_q[1];
                REG_STATUS:   rd_val = DATA_W'(status_word);
                REG_DMA_FULL: rd_val = DATA_W'(dma_full);
                REG_DMA_BUSY: rd_val = '0;
                REG_SEM:      rd_val = DATA_W'(sem_busy);
                default:      rd_val = '0;
            endcase
        end
        if (!rd_hit) rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            bus_rerr   <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_val : '0;
            bus_rerr   <= bus_rd && !rd_hit;
        end
    end

    assign dma_start    = req_q.start;
    assign dma_dir      = req_q.dir;
    assign dma_bank     = req_q.bank;
    assign dma_len      = req_q.len;
    assign dma_mem_addr = mem_addr_q;
    assign dma_ext_addr = ext_addr_q;
    assign run_en       = !halt;
    assign pc_value     = pc_q;

    // R9: the PC cannot move while running
    assert_pc_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !halt |=> $stable(pc_q));

    // R11: an error response carries zero data
    assert_rerr_zero_R11: assert property (@(posedge clk) disable iff (rst)
        bus_rerr |-> (bus_rvalid && bus_rdata == '0));

    // R12: read data only follows a read strobe
    assert_rvalid_follow_R12: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_rd));

endmodule

// File: tb/test_cop_csr.sv
module test_cop_csr;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_pc_win = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_rerr;
    logic [31:0] bus_rdata;
    logic        core_brk = 1'b0, dma_full = 1'b0;
    logic        dma_start, dma_dir, dma_bank;
    logic [31:0] dma_len, dma_mem_addr, dma_ext_addr;
    logic        irq_raise, irq_lower, run_en, pc_load;
    logic [1:0]  step_cnt;
    logic [11:0] pc_value;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_csr i_cop_csr (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_pc_win(bus_pc_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
        .core_brk(core_brk), .dma_full(dma_full), .dma_start(dma_start),
        .dma_dir(dma_dir), .dma_bank(dma_bank), .dma_len(dma_len),
        .dma_mem_addr(dma_mem_addr), .dma_ext_addr(dma_ext_addr),
        .irq_raise(irq_raise), .irq_lower(irq_lower), .run_en(run_en),
        .step_cnt(step_cnt), .pc_value(pc_value), .pc_load(pc_load)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        m_halt, m_broke, m_sstep, m_iob, m_sem;
    bit [7:0]  m_sig;
    int        m_cnt;
    bit [31:0] m_maddr, m_eaddr, m_len0, m_len1, m_pc;
    bit        e_rvalid, e_rerr, e_start, e_dir, e_bank, e_raise, e_lower, e_pcload;
    bit [31:0] e_rdata, e_len;
    int        e_step;
    string     e_tag = "R12";

    function automatic bit [1:0] pair(input bit clr, input bit set, input bit cur);
        if (clr && !set) return 2'b00;
        if (set && !clr) return 2'b01;
        return {1'b0, cur};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_halt = 1; m_broke = 0; m_sstep = 0; m_iob = 0; m_sem = 0; m_sig = 0;
            m_cnt = 0; m_maddr = 0; m_eaddr = 0; m_len0 = 0; m_len1 = 0; m_pc = 0;
            e_rvalid = 0; e_rerr = 0; e_start = 0; e_raise = 0; e_lower = 0;
            e_pcload = 0; e_rdata = 0; e_step = 0; e_len = 0; e_dir = 0; e_bank = 0;
        end else begin
            bit old_halt;
            bit take;
            bit w;
            old_halt = m_halt;
            take = 0;
            // reads see the state before this cycle's writes
            e_rvalid = bus_rd; e_rerr = 0; e_rdata = 0;
            if (bus_rd) begin
                if (bus_pc_win) begin
                    if (bus_addr == 0) begin e_rdata = m_pc; e_tag = "R9"; end
                    else begin e_rerr = 1; e_tag = "R11"; end
                end else if (bus_addr[1:0] != 0 || bus_addr >= 8'h20) begin
                    e_rerr = 1; e_tag = "R11";
                end else begin
                    case (bus_addr)
                        8'h00: begin e_rdata = m_maddr; e_tag = "R2"; end
                        8'h04: begin e_rdata = m_eaddr; e_tag = "R2"; end
                        8'h08: begin e_rdata = m_len0; e_tag = "R3"; end
                        8'h0C: begin e_rdata = m_len1; e_tag = "R3"; end
                        8'h10: begin e_rdata = {20'd0, m_sig, m_iob, m_sstep, m_broke, m_halt}; e_tag = "R7"; end
                        8'h14: begin e_rdata = {31'd0, dma_full}; e_tag = "R11"; end
                        8'h18: begin e_rdata = 0; e_tag = "R11"; end
                        default: begin e_rdata = {31'd0, m_sem}; e_tag = "R8"; take = 1; end
                    endcase
                end
            end
            e_start = 0; e_raise = 0; e_lower = 0; e_pcload = 0;
            w = bus_wr && !bus_pc_win;
            // step ratio gate
            if (w && bus_addr == 8'h10 && bus_wdata[1] && !bus_wdata[0]) begin
                m_cnt = 0; e_step = 0;
            end else if (!old_halt) begin
                m_cnt = m_cnt + 1;
                if (m_cnt > 2) begin e_step = 2; m_cnt = m_cnt - 3; end
                else e_step = 0;
            end else e_step = 0;
            if (take) m_sem = 1;
            if (w) begin
                case (bus_addr)
                    8'h00: m_maddr = bus_wdata & 32'h1FF8;
                    8'h04: m_eaddr = bus_wdata & 32'hFFFFF8;
                    8'h08, 8'h0C: begin
                        if (bus_addr == 8'h08) m_len0 = bus_wdata; else m_len1 = bus_wdata;
                        e_start = 1; e_dir = (bus_addr == 8'h0C);
                        e_bank = m_maddr[12]; e_len = bus_wdata;
                    end
                    8'h10: begin
                        m_halt  = pair(bus_wdata[0], bus_wdata[1], m_halt)[0];
                        e_raise = bus_wdata[4] && !bus_wdata[3];
                        e_lower = bus_wdata[3] && !bus_wdata[4];
                        if (bus_wdata[2]) m_broke = 0;
                        m_sstep = pair(bus_wdata[5], bus_wdata[6], m_sstep)[0];
                        m_iob   = pair(bus_wdata[7], bus_wdata[8], m_iob)[0];
                        for (int k = 0; k < 8; k++)
                            m_sig[k] = pair(bus_wdata[9+2*k], bus_wdata[10+2*k], m_sig[k])[0];
                    end
                    8'h1C: m_sem = 0;
                    default: ;
                endcase
            end
            if (core_brk) m_broke = 1;
            if (bus_wr && bus_pc_win && bus_addr == 0 && old_halt) begin
                m_pc = bus_wdata & 32'hFFC; e_pcload = 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 run_en", {31'd0, run_en}, {31'd0, !m_halt});
            check("R10 step_cnt", {30'd0, step_cnt}, e_step);
            check("R5 irq_raise", {31'd0, irq_raise}, {31'd0, e_raise});
            check("R5 irq_lower", {31'd0, irq_lower}, {31'd0, e_lower});
            check("R3 dma_start", {31'd0, dma_start}, {31'd0, e_start});
            if (e_start) begin
                check("R3 dma_dir", {31'd0, dma_dir}, {31'd0, e_dir});
                check("R3 dma_bank", {31'd0, dma_bank}, {31'd0, e_bank});
                check("R3 dma_len", dma_len, e_len);
            end
            check("R2 dma_mem_addr", dma_mem_addr, m_maddr);
            check("R2 dma_ext_addr", dma_ext_addr, m_eaddr);
            check("R9 pc_value", {20'd0, pc_value}, m_pc);
            check("R9 pc_load", {31'd0, pc_load}, {31'd0, e_pcload});
            check("R12 rvalid", {31'd0, bus_rvalid}, {31'd0, e_rvalid});
            if (e_rvalid) begin
                check({e_tag, " rdata"}, bus_rdata, e_rdata);
                check("R11 rerr", {31'd0, bus_rerr}, {31'd0, e_rerr});
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input bit pcw, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_pc_win = pcw; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_pc_win = 0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input bit pcw, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1; bus_pc_win = pcw; bus_addr = a;
        @(negedge clk);
        bus_rd = 0; bus_pc_win = 0;
        check(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int grants;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        check("R1 step_cnt", {30'd0, step_cnt}, 32'd0);
        rd_exp(8'h10, 0, 32'h1, "R1 status");
        rd_exp(8'h00, 1, 32'h0, "R1 pc");
        // R2 address masking
        wr(8'h00, 0, 32'hFFFF_FFFF);
        rd_exp(8'h00, 0, 32'h1FF8, "R2 mem addr");
        wr(8'h04, 0, 32'hFFFF_FFFF);
        rd_exp(8'h04, 0, 32'hFF_FFF8, "R2 ext addr");
        // R3 DMA start, bank 1 then bank 0
        wr(8'h08, 0, 32'h0000_0123);
        check("R3 start", {31'd0, dma_start}, 32'd1);
        check("R3 bank1", {31'd0, dma_bank}, 32'd1);
        check("R3 dir0", {31'd0, dma_dir}, 32'd0);
        wr(8'h00, 0, 32'h0000_0008);
        wr(8'h0C, 0, 32'h00AB_0040);
        check("R3 bank0", {31'd0, dma_bank}, 32'd0);
        check("R3 dir1", {31'd0, dma_dir}, 32'd1);
        check("R3 len", dma_len, 32'h00AB_0040);
        rd_exp(8'h08, 0, 32'h0000_0123, "R3 len0 readback");
        // R9 PC write while halted
        wr(8'h00, 1, 32'hFFFF_FFFF);
        rd_exp(8'h00, 1, 32'hFFC, "R9 pc masked");
        // R4 clear halt, R10 cadence
        wr(8'h10, 0, 32'h1);
        check("R4 running", {31'd0, run_en}, 32'd1);
        grants = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (step_cnt == 2) grants++;
        end
        check("R10 grants in 30 cycles", grants, 32'd10);
        // R9 PC write ignored while running
        wr(8'h00, 1, 32'h0000_0100);
        rd_exp(8'h00, 1, 32'hFFC, "R9 pc locked");
        // R4 both bits: unchanged; then set-only halts
        wr(8'h10, 0, 32'h3);
        check("R4 both keep", {31'd0, run_en}, 32'd1);
        wr(8'h10, 0, 32'h2);
        check("R4 halted", {31'd0, run_en}, 32'd0);
        repeat (6) @(negedge clk);
        check("R10 no grant halted", {30'd0, step_cnt}, 32'd0);
        // R5 interrupt requests
        wr(8'h10, 0, 32'h10);
        check("R5 raise", {31'd0, irq_raise}, 32'd1);
        wr(8'h10, 0, 32'h08);
        check("R5 lower", {31'd0, irq_lower}, 32'd1);
        wr(8'h10, 0, 32'h18);
        check("R5 both none", {31'd0, irq_raise | irq_lower}, 32'd0);
        // R6 broke
        @(negedge clk); core_brk = 1; @(negedge clk); core_brk = 0;
        rd_exp(8'h10, 0, 32'h3, "R6 broke set");
        wr(8'h10, 0, 32'h4);
        rd_exp(8'h10, 0, 32'h1, "R6 broke clear");
        // R7 other pairs: set sstep, iob, sig3, sig7
        wr(8'h10, 0, (32'h1 << 6) | (32'h1 << 8) | (32'h1 << 16) | (32'h1 << 24));
        rd_exp(8'h10, 0, 32'h1 | 32'h4 | 32'h8 | (32'h1 << 7) | (32'h1 << 11), "R7 set pairs");
        // both on sig3 keeps, clear-only on sig7 and sstep
        wr(8'h10, 0, (32'h3 << 15) | (32'h1 << 23) | (32'h1 << 5));
        rd_exp(8'h10, 0, 32'h1 | 32'h8 | (32'h1 << 7), "R7 keep and clear");
        // R8 semaphore
        rd_exp(8'h1C, 0, 32'h0, "R8 first read");
        rd_exp(8'h1C, 0, 32'h1, "R8 second read");
        wr(8'h1C, 0, 32'hDEAD_BEEF);
        rd_exp(8'h1C, 0, 32'h0, "R8 after release");
        @(negedge clk);
        bus_rd = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 0;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        check("R8 simultaneous read data", bus_rdata, 32'h1);
        rd_exp(8'h1C, 0, 32'h0, "R8 release wins");
        // R11 odd offsets
        dma_full = 1;
        rd_exp(8'h14, 0, 32'h1, "R11 dma full");
        dma_full = 0;
        rd_exp(8'h18, 0, 32'h0, "R11 dma busy");
        rd_exp(8'h20, 0, 32'h0, "R11 unmapped");
        check("R11 rerr", {31'd0, bus_rerr}, 32'd1);
        rd_exp(8'h02, 0, 32'h0, "R11 misaligned");
        rd_exp(8'h04, 1, 32'h0, "R11 pc window offset");
        check("R11 rerr pc", {31'd0, bus_rerr}, 32'd1);
        // R12 read during write sees old value
        @(negedge clk);
        bus_rd = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h0000_1000;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        check("R12 old value", bus_rdata, 32'hFF_FFF8);
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule